// File: doc/BRIEF.md
# Multi-Mode Cartridge Bank Address Translator

This block turns a CPU program address in the upper 32 KB (0x8000–0xFFFF) into an 8 KB program-bank number, and a video address in the 8 KB pattern space (0x0000–0x1FFF) into a 1 KB character-bank number. A two-bit mode field picks one of four inner banking schemes:

- **External:** the inner bank numbers arrive as inputs from a scanline-counting mapper that sits beside this block.
- **Serial:** driven by four five-bit registers that a separate serial loader fills.
- **Switchable-16K:** a switchable 16 KB window with the top 16 KB fixed.
- **Fixed-32K:** the 32 KB program space is fixed and only the 8 KB character page switches.

Two outer-bank registers supply the high bank bits. These bits are ORed onto every inner bank number, for program and character sides alike. One configuration bit sends all character accesses to an external 8 KB RAM instead. In that case the block raises a select and passes the RAM index through.

The ROM arrays, the RAM array, the external mapper's interrupt logic and the serial shift loader all live outside. The translation is purely combinational from the address inputs and the register state. Register writes take effect on the next clock edge.

Top module: `bank_xlate`

## Requirements
- R1: After reset every register is zero: mode is External, outer bits are clear, character RAM is off, and all inner bank registers are zero.
- R2: A write to 0x411D keeps bits 2:0 only. Bits 1:0 are the mode, encoded 0 External, 1 Serial, 2 Switchable-16K and 3 Fixed-32K. Bit 2 enables character RAM.
- R3: A write to 0x412C keeps bits 3:0. Program outer bits: bit 0 feeds bank bit PRG_OUTER_LSB and bit 2 feeds PRG_OUTER_LSB+1. Character outer bits: bit 1 feeds bank bit CHR_OUTER_LSB and bit 3 feeds CHR_OUTER_LSB+1.
- R4: A write to 0x412E keeps bit 0 only. It feeds program bank bit PRG_OUTER_LSB+2 and character bank bit CHR_OUTER_LSB+2.
- R5: In External mode the program bank is the outer bits ORed with extPrgBank, and the character bank is the outer bits ORed with extChrBank.
- R6: In Switchable-16K mode, a CPU write to 0x8000–0xFFFF keeps 4 bits (v). Window 0x8000 maps to bank 2v and window 0xA000 to bank 2v+1. The character bank is the outer bits ORed with vidAddr[12:10].
- R7: In Switchable-16K mode, windows 0xC000 and 0xE000 map to PRG_BANKS-2 and PRG_BANKS-1. Each value saturates at zero.
- R8: In Fixed-32K mode, a CPU write to 0x8000–0xFFFF keeps 2 bits (c). The program bank is cpuAddr[14:13]. The character bank is c*8 + vidAddr[12:10]. Outer bits are ORed onto both.
- R9: In Serial mode, control bits 3:2 pick the program layout from the program register's low 4 bits (b):
  - 0 or 1: bank (b & ~1)*2 + cpuAddr[14:13].
  - 2: banks 0, 1, 2b and 2b+1 in the four windows.
  - 3: banks 2b, 2b+1, PRG_BANKS-2 and PRG_BANKS-1 in the four windows.
- R10: In Serial mode, control bit 4 clear gives character bank (chr0 & 0x1E)*4 + vidAddr[12:10]. Bit 4 set gives chr0*4 for 0x0000–0x0FFF and chr1*4 for 0x1000–0x1FFF, each plus vidAddr[11:10].
- R11: When character RAM is enabled, chrRamSel is 1 and chrRamIdx equals vidAddr, whatever the mode.
- R12: A pulse on serLoad stores serData into the register chosen by serSel (0 control, 1 chr0, 2 chr1, 3 program). The store happens only while the mode is Serial; otherwise the pulse has no effect.
- R13: CPU writes to 0x8000–0xFFFF in External or Serial mode change no register here. Writes to other addresses below 0x8000 change nothing. A CPU address below 0x8000 gives program bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | CPU write strobe |
| wrAddr | input | 16 | CPU write address |
| wrData | input | 8 | CPU write data |
| serLoad | input | 1 | Serial loader completion pulse |
| serSel | input | 2 | Serial target register select |
| serData | input | 5 | Serial loaded value |
| cpuAddr | input | 16 | CPU read address to translate |
| extPrgBank | input | PRG_OUTER_LSB | External mapper program inner bank |
| vidAddr | input | 13 | Video pattern address to translate |
| extChrBank | input | CHR_OUTER_LSB | External mapper character inner bank |
| prgBank | output | PRG_OUTER_LSB+3 | 8 KB program bank number |
| chrBank | output | CHR_OUTER_LSB+3 | 1 KB character bank number |
| chrRamSel | output | 1 | Character access goes to RAM |
| chrRamIdx | output | 13 | Character RAM index |

## Verification
The bench builds the main instance with PRG_BANKS=32, PRG_OUTER_LSB=12 and CHR_OUTER_LSB=15. With these values the fixed last banks land at 30 and 31, and every outer bit sits clear of the inner bank bits, so the ORed offsets show as distinct bank values. A second instance with PRG_BANKS=1 takes the same stimulus. It brings the zero-saturation of both fixed banks within reach. With the serial registers loaded straight through the parallel port, every serial sub-mode and both character layouts can be set up in a few cycles.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;

  typedef enum logic [1:0] {
    MODE_EXT   = 2'd0,
    MODE_SER   = 2'd1,
    MODE_SW16  = 2'd2,
    MODE_FIX32 = 2'd3
  } modeT;

  // architectural state of the translator
  typedef struct packed {
    modeT       mode;
    logic       ramEn;
    logic [3:0] outer;    // {chrA26, prgA26, chrA25, prgA25}
    logic       top;      // A27 for both sides
    logic [3:0] romSel;   // switchable-16K register
    logic [1:0] chrSel;   // fixed-32K character register
    logic [4:0] serCtl;
    logic [4:0] serChr0;
    logic [4:0] serChr1;
    logic [4:0] serPrg;
  } bankRegsT;

  // write strobes from control to datapath
  typedef struct packed {
    logic       cfgWe;
    logic       outerWe;
    logic       topWe;
    logic       romSelWe;
    logic       chrSelWe;
    logic [3:0] serWe;    // one-hot: ctl, chr0, chr1, prg
  } strobesT;

endpackage

// File: rtl/bank_xlate_ctrl.sv
module bank_xlate_ctrl
  import bank_xlate_pkg::*;
#(
  parameter logic [15:0] CFG_ADDR   = 16'h411D,
  parameter logic [15:0] OUTER_ADDR = 16'h412C,
  parameter logic [15:0] TOP_ADDR   = 16'h412E
) (
  input  logic        wrEn,
  input  logic [15:0] wrAddr,
  input  logic        serLoad,
  input  logic [1:0]  serSel,
  input  modeT        mode,
  output strobesT     strobes
);

  logic hiWrite;

  assign hiWrite = wrEn && wrAddr[15];

  always_comb begin
    strobes          = '0;
    strobes.cfgWe    = wrEn && (wrAddr == CFG_ADDR);
    strobes.outerWe  = wrEn && (wrAddr == OUTER_ADDR);
    strobes.topWe    = wrEn && (wrAddr == TOP_ADDR);
    strobes.romSelWe = hiWrite && (mode == MODE_SW16);
    strobes.chrSelWe = hiWrite && (mode == MODE_FIX32);
    if (serLoad && (mode == MODE_SER)) begin
      strobes.serWe = 4'b0001 << serSel;
    end
  end

endmodule

// File: rtl/bank_xlate_regs.sv
module bank_xlate_regs
  import bank_xlate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobesT    strobes,
  input  logic [7:0] wrData,
  input  logic [4:0] serData,
  output bankRegsT   regsQ
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regsQ <= '0;
    end else begin
      if (strobes.cfgWe) begin
        regsQ.mode  <= modeT'(wrData[1:0]);
        regsQ.ramEn <= wrData[2];
      end
      if (strobes.outerWe)  regsQ.outer   <= wrData[3:0];
      if (strobes.topWe)    regsQ.top     <= wrData[0];
      if (strobes.romSelWe) regsQ.romSel  <= wrData[3:0];
      if (strobes.chrSelWe) regsQ.chrSel  <= wrData[1:0];
      if (strobes.serWe[0]) regsQ.serCtl  <= serData;
      if (strobes.serWe[1]) regsQ.serChr0 <= serData;
      if (strobes.serWe[2]) regsQ.serChr1 <= serData;
      if (strobes.serWe[3]) regsQ.serPrg  <= serData;
    end
  end

endmodule

// File: rtl/bank_xlate_prg.sv
module bank_xlate_prg
  import bank_xlate_pkg::*;
#(
  parameter int PRG_BANKS     = 32,
  parameter int PRG_OUTER_LSB = 12
) (
  input  bankRegsT                    regsQ,
  input  logic [15:0]                 cpuAddr,
  input  logic [PRG_OUTER_LSB-1:0]    extPrgBank,
  output logic [PRG_OUTER_LSB+2:0]    prgBank
);

  localparam int IW    = PRG_OUTER_LSB;
  localparam int LASTI = (PRG_BANKS >= 1) ? PRG_BANKS - 1 : 0;
  localparam int PREVI = (PRG_BANKS >= 2) ? PRG_BANKS - 2 : 0;
  localparam logic [IW-1:0] LAST = IW'(LASTI);
  localparam logic [IW-1:0] PREV = IW'(PREVI);

  logic [1:0]    slot;
  logic [3:0]    b16;
  logic [IW-1:0] inner;
  logic [IW-1:0] swLo, swHi, serLo, serHi, ser32;
  logic [2:0]    outerBits;

  assign slot      = cpuAddr[14:13];
  assign b16       = regsQ.serPrg[3:0];
  assign swLo      = IW'({regsQ.romSel, 1'b0});
  assign swHi      = IW'({regsQ.romSel, 1'b1});
  assign serLo     = IW'({b16, 1'b0});
  assign serHi     = IW'({b16, 1'b1});
  assign ser32     = IW'({b16[3:1], slot});
  assign outerBits = {regsQ.top, regsQ.outer[2], regsQ.outer[0]};

  always_comb begin
    inner = '0;
    unique case (regsQ.mode)
      MODE_EXT:   inner = extPrgBank;
      MODE_FIX32: inner = IW'(slot);
      MODE_SW16: begin
        case (slot)
          2'd0:    inner = swLo;
          2'd1:    inner = swHi;
          2'd2:    inner = PREV;
          default: inner = LAST;
        endcase
      end
      MODE_SER: begin
        case (regsQ.serCtl[3:2])
          2'd2: begin
            case (slot)
              2'd0:    inner = '0;
              2'd1:    inner = IW'(1);
              2'd2:    inner = serLo;
              default: inner = serHi;
            endcase
          end
          2'd3: begin
            case (slot)
              2'd0:    inner = serLo;
              2'd1:    inner = serHi;
              2'd2:    inner = PREV;
              default: inner = LAST;
            endcase
          end
          default: inner = ser32;
        endcase
      end
      default: inner = '0;
    endcase
  end

  assign prgBank = cpuAddr[15] ? {outerBits, inner} : '0;

endmodule

// File: rtl/bank_xlate_chr.sv
module bank_xlate_chr
  import bank_xlate_pkg::*;
#(
  parameter int CHR_OUTER_LSB = 15
) (
  input  bankRegsT                   regsQ,
  input  logic [12:0]                vidAddr,
  input  logic [CHR_OUTER_LSB-1:0]   extChrBank,
  output logic [CHR_OUTER_LSB+2:0]   chrBank,
  output logic                       chrRamSel,
  output logic [12:0]                chrRamIdx
);

  localparam int IW = CHR_OUTER_LSB;

  logic [2:0]    sub;
  logic [4:0]    half;
  logic [IW-1:0] inner;
  logic [2:0]    outerBits;

  assign sub       = vidAddr[12:10];
  assign half      = vidAddr[12] ? regsQ.serChr1 : regsQ.serChr0;
  assign outerBits = {regsQ.top, regsQ.outer[3], regsQ.outer[1]};

  always_comb begin
    inner = '0;
    unique case (regsQ.mode)
      MODE_EXT:   inner = extChrBank;
      MODE_SW16:  inner = IW'(sub);
      MODE_FIX32: inner = IW'({regsQ.chrSel, sub});
      MODE_SER: begin
        if (regsQ.serCtl[4]) inner = IW'({half, vidAddr[11:10]});
        else                 inner = IW'({regsQ.serChr0[4:1], sub});
      end
      default: inner = '0;
    endcase
  end

  assign chrBank   = {outerBits, inner};
  assign chrRamSel = regsQ.ramEn;
  assign chrRamIdx = vidAddr;

endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bank_xlate_pkg::*;
#(
  parameter int          PRG_BANKS     = 32,
  parameter int          PRG_OUTER_LSB = 12,
  parameter int          CHR_OUTER_LSB = 15,
  parameter logic [15:0] CFG_ADDR      = 16'h411D,
  parameter logic [15:0] OUTER_ADDR    = 16'h412C,
  parameter logic [15:0] TOP_ADDR      = 16'h412E
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [15:0]                wrAddr,
  input  logic [7:0]                 wrData,
  input  logic                       serLoad,
  input  logic [1:0]                 serSel,
  input  logic [4:0]                 serData,
  input  logic [15:0]                cpuAddr,
  input  logic [PRG_OUTER_LSB-1:0]   extPrgBank,
  input  logic [12:0]                vidAddr,
  input  logic [CHR_OUTER_LSB-1:0]   extChrBank,
  output logic [PRG_OUTER_LSB+2:0]   prgBank,
  output logic [CHR_OUTER_LSB+2:0]   chrBank,
  output logic                       chrRamSel,
  output logic [12:0]                chrRamIdx
);

  strobesT  strobes;
  bankRegsT regsQ;

  bank_xlate_ctrl #(
    .CFG_ADDR(CFG_ADDR), .OUTER_ADDR(OUTER_ADDR), .TOP_ADDR(TOP_ADDR)
  ) ctrlI (
    .wrEn(wrEn), .wrAddr(wrAddr), .serLoad(serLoad), .serSel(serSel),
    .mode(regsQ.mode), .strobes(strobes)
  );

  bank_xlate_regs regsI (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .serData(serData), .regsQ(regsQ)
  );

  bank_xlate_prg #(
    .PRG_BANKS(PRG_BANKS), .PRG_OUTER_LSB(PRG_OUTER_LSB)
  ) prgI (
    .regsQ(regsQ), .cpuAddr(cpuAddr), .extPrgBank(extPrgBank), .prgBank(prgBank)
  );

  bank_xlate_chr #(
    .CHR_OUTER_LSB(CHR_OUTER_LSB)
  ) chrI (
    .regsQ(regsQ), .vidAddr(vidAddr), .extChrBank(extChrBank),
    .chrBank(chrBank), .chrRamSel(chrRamSel), .chrRamIdx(chrRamIdx)
  );

endmodule

// File: rtl/bank_xlate_chk.sv
module bank_xlate_chk
  import bank_xlate_pkg::*;
#(
  parameter int          PRG_BANKS     = 32,
  parameter int          PRG_OUTER_LSB = 12,
  parameter logic [15:0] CFG_ADDR      = 16'h411D,
  parameter logic [15:0] OUTER_ADDR    = 16'h412C,
  parameter logic [15:0] TOP_ADDR      = 16'h412E
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic [15:0]              wrAddr,
  input logic [7:0]               wrData,
  input logic                     serLoad,
  input logic [15:0]              cpuAddr,
  input logic [PRG_OUTER_LSB+2:0] prgBank,
  input bankRegsT                 regsQ
);

  localparam int LASTI = (PRG_BANKS >= 1) ? PRG_BANKS - 1 : 0;
  localparam logic [PRG_OUTER_LSB-1:0] LAST = PRG_OUTER_LSB'(LASTI);

  a_r2_cfg_keep: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == CFG_ADDR) |=> ({regsQ.ramEn, regsQ.mode} == $past(wrData[2:0])));

  a_r3_outer_keep: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == OUTER_ADDR) |=> (regsQ.outer == $past(wrData[3:0])));

  a_r4_top_keep: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == TOP_ADDR) |=> (regsQ.top == $past(wrData[0])));

  a_r6_rom_sel_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr[15] && regsQ.mode == MODE_SW16) |=> (regsQ.romSel == $past(wrData[3:0])));

  a_r7_last_window: assert property (@(posedge clk) disable iff (!rstN)
    (regsQ.mode == MODE_SW16 && cpuAddr[15:13] == 3'b111) |->
      (prgBank[PRG_OUTER_LSB-1:0] == LAST));

  a_r8_linear_prg: assert property (@(posedge clk) disable iff (!rstN)
    (regsQ.mode == MODE_FIX32 && cpuAddr[15]) |->
      (prgBank[PRG_OUTER_LSB-1:0] == PRG_OUTER_LSB'(cpuAddr[14:13])));

  a_r12_ser_gated: assert property (@(posedge clk) disable iff (!rstN)
    (serLoad && regsQ.mode != MODE_SER && !wrEn) |=>
      $stable({regsQ.serCtl, regsQ.serChr0, regsQ.serChr1, regsQ.serPrg}));

  a_r13_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuAddr[15]) |-> (prgBank == '0));

endmodule

bind bank_xlate bank_xlate_chk #(
  .PRG_BANKS(PRG_BANKS), .PRG_OUTER_LSB(PRG_OUTER_LSB),
  .CFG_ADDR(CFG_ADDR), .OUTER_ADDR(OUTER_ADDR), .TOP_ADDR(TOP_ADDR)
) chkI (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .serLoad(serLoad), .cpuAddr(cpuAddr), .prgBank(prgBank), .regsQ(regsQ)
);

// File: tb/bank_xlate_test.sv
`timescale 1ns/1ps
module bank_xlate_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        serLoad = 1'b0;
  logic [1:0]  serSel = '0;
  logic [4:0]  serData = '0;
  logic [15:0] cpuAddr = 16'h8000;
  logic [11:0] extPrgBank = 12'd5;
  logic [12:0] vidAddr = '0;
  logic [14:0] extChrBank = 15'd9;
  logic [14:0] prgBank, prgBankOne;
  logic [17:0] chrBank, chrBankOne;
  logic        chrRamSel, chrRamSelOne;
  logic [12:0] chrRamIdx, chrRamIdxOne;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bank_xlate uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .serLoad(serLoad), .serSel(serSel), .serData(serData), .cpuAddr(cpuAddr),
    .extPrgBank(extPrgBank), .vidAddr(vidAddr), .extChrBank(extChrBank),
    .prgBank(prgBank), .chrBank(chrBank), .chrRamSel(chrRamSel), .chrRamIdx(chrRamIdx)
  );

  bank_xlate #(.PRG_BANKS(1)) uutOne (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .serLoad(serLoad), .serSel(serSel), .serData(serData), .cpuAddr(cpuAddr),
    .extPrgBank(extPrgBank), .vidAddr(vidAddr), .extChrBank(extChrBank),
    .prgBank(prgBankOne), .chrBank(chrBankOne), .chrRamSel(chrRamSelOne),
    .chrRamIdx(chrRamIdxOne)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic serWrite(input logic [1:0] s, input logic [4:0] d);
    @(negedge clk);
    serLoad = 1'b1; serSel = s; serData = d;
    @(negedge clk);
    serLoad = 1'b0;
  endtask

  task automatic prgAt(input logic [15:0] a, input logic [31:0] exp, input string req);
    cpuAddr = a; #1;
    chk(req, 32'(prgBank), exp);
  endtask

  task automatic chrAt(input logic [12:0] a, input logic [31:0] exp, input string req);
    vidAddr = a; #1;
    chk(req, 32'(chrBank), exp);
  endtask

  task automatic testReset();
    prgAt(16'h8000, 32'd5, "R1 reset external prg");
    chrAt(13'h0000, 32'd9, "R1 reset external chr");
    chk("R1 reset ram off", 32'(chrRamSel), 32'd0);
  endtask

  task automatic testConfig();
    cpuWrite(16'h411D, 8'hFF);            // mode 3, RAM on, junk upper bits
    #1 chk("R2 ram bit", 32'(chrRamSel), 32'd1);
    prgAt(16'hE000, 32'd3, "R2 mode field fixed-32K");
    cpuWrite(16'h411D, 8'h00);
    prgAt(16'hA000, 32'd5, "R2 mode back external");
    #1 chk("R2 ram bit cleared", 32'(chrRamSel), 32'd0);
  endtask

  task automatic testOuter();
    cpuWrite(16'h412C, 8'hFF);
    cpuWrite(16'h412E, 8'hFF);
    prgAt(16'h8000, 32'h7005, "R5 ext prg with all outer");
    chrAt(13'h0400, 32'h38009, "R5 ext chr with all outer");
    cpuWrite(16'h412E, 8'h00);
    cpuWrite(16'h412C, 8'h05);
    prgAt(16'h8000, 32'h3005, "R3 prg outer bits 0,2");
    chrAt(13'h0400, 32'd9, "R3 chr unaffected by prg bits");
    cpuWrite(16'h412C, 8'h0A);
    prgAt(16'h8000, 32'd5, "R3 prg unaffected by chr bits");
    chrAt(13'h0400, 32'h18009, "R3 chr outer bits 1,3");
    cpuWrite(16'h412C, 8'h00);
    cpuWrite(16'h412E, 8'hFE);            // bit 0 clear
    prgAt(16'h8000, 32'd5, "R4 top keeps only bit 0");
    cpuWrite(16'h412E, 8'h01);
    prgAt(16'h8000, 32'h4005, "R4 top prg bit");
    chrAt(13'h0400, 32'h20009, "R4 top chr bit");
    cpuWrite(16'h412E, 8'h00);
  endtask

  task automatic testSw16();
    cpuWrite(16'h411D, 8'h02);
    cpuWrite(16'h9000, 8'hF3);
    prgAt(16'h8000, 32'd6, "R6 low window 2v");
    prgAt(16'hA000, 32'd7, "R6 second window 2v+1");
    prgAt(16'hC000, 32'd30, "R7 second-to-last");
    prgAt(16'hE000, 32'd31, "R7 last");
    cpuAddr = 16'hC000; #1 chk("R7 saturate prev at one bank", 32'(prgBankOne), 32'd0);
    cpuAddr = 16'hE000; #1 chk("R7 saturate last at one bank", 32'(prgBankOne), 32'd0);
    chrAt(13'h1C00, 32'd7, "R6 chr linear");
    cpuWrite(16'hFFFF, 8'hFF);
    prgAt(16'h8000, 32'd30, "R6 keeps 4 bits");
    cpuWrite(16'h412C, 8'h01);
    prgAt(16'hA000, 32'h101F, "R6 outer ORed");
    prgAt(16'hC000, 32'h101E, "R7 outer ORed on fixed");
    cpuWrite(16'h412C, 8'h00);
  endtask

  task automatic testFix32();
    cpuWrite(16'h411D, 8'h03);
    cpuWrite(16'h8000, 8'hFE);
    chrAt(13'h0000, 32'd16, "R8 chr page 2 first");
    chrAt(13'h1C00, 32'd23, "R8 chr page 2 last");
    prgAt(16'hA000, 32'd1, "R8 prg linear A000");
    prgAt(16'hE000, 32'd3, "R8 prg linear E000");
    cpuWrite(16'h412C, 8'h02);
    chrAt(13'h0000, 32'h8010, "R8 chr outer ORed");
    cpuWrite(16'h412C, 8'h00);
    cpuWrite(16'h411D, 8'h02);
    prgAt(16'h8000, 32'd30, "R8 write did not touch 16K reg");
  endtask

  task automatic testSerPrg();
    cpuWrite(16'h411D, 8'h01);
    serWrite(2'd3, 5'd7);
    prgAt(16'h8000, 32'd12, "R9 sub0 window0");
    prgAt(16'hE000, 32'd15, "R9 sub0 window3");
    serWrite(2'd0, 5'h04);
    prgAt(16'hA000, 32'd13, "R9 sub1 window1");
    serWrite(2'd0, 5'h08);
    prgAt(16'h8000, 32'd0, "R9 sub2 fixed 0");
    prgAt(16'hA000, 32'd1, "R9 sub2 fixed 1");
    prgAt(16'hC000, 32'd14, "R9 sub2 switch lo");
    prgAt(16'hE000, 32'd15, "R9 sub2 switch hi");
    serWrite(2'd0, 5'h0C);
    prgAt(16'h8000, 32'd14, "R9 sub3 switch lo");
    prgAt(16'hC000, 32'd30, "R9 sub3 fixed prev");
    prgAt(16'hE000, 32'd31, "R9 sub3 fixed last");
  endtask

  task automatic testSerChr();
    serWrite(2'd1, 5'd3);
    chrAt(13'h0000, 32'd8, "R10 8K ignores chr0 bit0");
    chrAt(13'h1C00, 32'd15, "R10 8K last page");
    serWrite(2'd0, 5'h1C);
    serWrite(2'd1, 5'd2);
    serWrite(2'd2, 5'd3);
    chrAt(13'h0000, 32'd8, "R10 4K chr0");
    chrAt(13'h0C00, 32'd11, "R10 4K chr0 last");
    chrAt(13'h1000, 32'd12, "R10 4K chr1");
    chrAt(13'h1400, 32'd13, "R10 4K chr1 second");
  endtask

  task automatic testIgnored();
    cpuWrite(16'h8000, 8'h00);            // serial mode: no register here
    prgAt(16'h8000, 32'd14, "R13 high write ignored in serial");
    cpuWrite(16'h411D, 8'h02);
    serWrite(2'd3, 5'h1F);                // not serial mode: ignored
    cpuWrite(16'h411D, 8'h01);
    prgAt(16'h8000, 32'd14, "R12 load ignored outside serial");
    cpuWrite(16'h411D, 8'h00);
    cpuWrite(16'hC000, 8'h00);            // external mode: ignored
    cpuWrite(16'h411C, 8'h03);            // neighbour address: ignored
    prgAt(16'h8000, 32'd5, "R13 neighbour address ignored");
    cpuWrite(16'h411D, 8'h02);
    prgAt(16'h8000, 32'd30, "R13 external-mode write ignored");
    prgAt(16'h6000, 32'd0, "R13 low address bank 0");
  endtask

  task automatic testRam();
    cpuWrite(16'h411D, 8'h06);
    vidAddr = 13'h1ABC; #1;
    chk("R11 ram select", 32'(chrRamSel), 32'd1);
    chk("R11 ram index", 32'(chrRamIdx), 32'h1ABC);
    prgAt(16'hA000, 32'd31, "R11 prg keeps mode");
    cpuWrite(16'h411D, 8'h05);
    #1 chk("R11 ram select in serial", 32'(chrRamSel), 32'd1);
    cpuWrite(16'h411D, 8'h02);
    #1 chk("R11 ram select off", 32'(chrRamSel), 32'd0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testConfig();
    testOuter();
    testSw16();
    testFix32();
    testSerPrg();
    testSerChr();
    testIgnored();
    testRam();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule